// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a flash command register. It watches the host's write cycles, one at a time. Each cycle carries an address and a byte of data. The block recognises the multi-cycle unlock sequences that select flash operations and turns each recognised command into a start pulse that lasts one clock. The operations are byte program (with the captured target address and data), chip erase, sector erase (with a mask of the selected sectors), autoselect entry, reset, erase suspend and erase resume. The program and erase engines that receive these pulses report back through done inputs.

During command and unlock cycles only the low eleven address bits are compared; the upper bits are ignored. A wrong address or data value in any cycle drops the partial sequence. Once an operation has started, writes are filtered. A program in progress ignores every write. An erase in progress accepts only the suspend byte, and a suspended erase accepts only the resume byte.

After a sector erase command, a load window stays open. Each further sector write reloads it, and the erase start pulse fires only when the window has run out with no new write. The width of the window is a parameter counted in clock cycles. A mode output always tells whether the decoder is in read-array, autoselect, busy or erase-suspended mode.

Top module: `flashCmdDecoder`

## Requirements
- R1: After reset, mode is read-array (encoding 2'b00), all seven pulse outputs are low and sectorMask is zero.
- R2: Three writes (AAh at 555h, 55h at 2AAh, A0h at 555h) followed by any fourth write raise progStart for exactly one cycle, with progAddr and progData equal to that fourth write, and mode becomes busy (2'b10). Only address bits 10:0 are compared on the first three writes.
- R3: The writes AAh@555h, 55h@2AAh, 90h@555h raise autoselEnter for one cycle and set mode to autoselect (2'b01). In that mode every write other than F0h leaves mode and all pulses unchanged.
- R4: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise chipEraseStart for one cycle, set every sectorMask bit and set mode to busy.
- R5: Replacing the sixth erase write with 30h at any address sets the sectorMask bit indexed by address bits [ADDR_W-1 -: SEC_BITS] and sets mode to busy. Each further 30h write ORs in its sector and restarts the window. sectorEraseStart fires for one cycle exactly WINDOW_CYCLES clock edges after the edge that took the last sector write.
- R6: Any write other than 30h or B0h during the load window returns mode to read-array, clears sectorMask and starts no erase. If that write is F0h, resetPulse also fires.
- R7: A wrong address or data value in any unlock or command cycle returns the decoder to read-array with no start pulse. F0h at any address in such a cycle, or in read-array mode, raises resetPulse.
- R8: While a program is busy, every write is ignored: no pulse fires and mode stays busy. progDone returns mode to read-array.
- R9: While an erase is busy, only B0h is accepted. It raises suspendPulse and sets mode to erase-suspended (2'b11). eraseDone returns mode to read-array and clears sectorMask.
- R10: In erase-suspended mode, 30h raises resumePulse and sets mode to busy, and all other writes are ignored. 30h in read-array mode raises no pulse.
- R11: B0h during the load window raises sectorEraseStart and suspendPulse in the same cycle, and mode becomes erase-suspended.
- R12: A 30h write sampled on the very edge at which the window would expire reloads the window instead, and no erase start fires on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One write cycle is present this clock |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| progDone | input | 1 | Program engine finished |
| eraseDone | input | 1 | Erase engine finished |
| progStart | output | 1 | Program start pulse |
| progAddr | output | ADDR_W | Captured program address |
| progData | output | 8 | Captured program data |
| chipEraseStart | output | 1 | Chip erase start pulse |
| sectorEraseStart | output | 1 | Sector erase start pulse |
| sectorMask | output | 2**SEC_BITS | Sectors selected for erase |
| autoselEnter | output | 1 | Autoselect entry pulse |
| resetPulse | output | 1 | Reset-to-read pulse |
| suspendPulse | output | 1 | Erase suspend pulse |
| resumePulse | output | 1 | Erase resume pulse |
| mode | output | 2 | 00 read, 01 autoselect, 10 busy, 11 suspended |

## Verification
Two things can meet in one clock. The first is window expiry and a new sector write. The bench waits until the window counter's last edge and then places a 30h write on exactly that edge. It checks that no erase start appears, that the new sector joins the mask and that a full fresh window follows. The second is that a suspend write inside the window must close the window and suspend at once. The bench checks that sectorEraseStart and suspendPulse are both high in the same sampled cycle, with mode reading erase-suspended.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG_SETUP,
    ST_ERS_SETUP,
    ST_ERS_UNL1,
    ST_ERS_UNL2,
    ST_SECT_WIN,
    ST_PROG_BUSY,
    ST_ERS_BUSY,
    ST_SUSPENDED,
    ST_AUTOSEL
  } seqState_e;

  localparam logic [1:0] MODE_READ    = 2'b00;
  localparam logic [1:0] MODE_AUTOSEL = 2'b01;
  localparam logic [1:0] MODE_BUSY    = 2'b10;
  localparam logic [1:0] MODE_SUSP    = 2'b11;

  localparam logic [7:0] BYTE_KEY1   = 8'hAA;
  localparam logic [7:0] BYTE_KEY2   = 8'h55;
  localparam logic [7:0] BYTE_PROG   = 8'hA0;
  localparam logic [7:0] BYTE_IDENT  = 8'h90;
  localparam logic [7:0] BYTE_ERASE  = 8'h80;
  localparam logic [7:0] BYTE_CHIP   = 8'h10;
  localparam logic [7:0] BYTE_SECTOR = 8'h30;
  localparam logic [7:0] BYTE_HALT   = 8'hB0;
  localparam logic [7:0] BYTE_RESET  = 8'hF0;

  localparam int unsigned CMD_ADDR_W = 11;
  localparam logic [CMD_ADDR_W-1:0] ADDR_KEY1 = 11'h555;
  localparam logic [CMD_ADDR_W-1:0] ADDR_KEY2 = 11'h2AA;

  typedef struct packed {
    logic progGo;
    logic chipGo;
    logic sectGo;
    logic autoGo;
    logic rstGo;
    logic suspGo;
    logic resGo;
    logic captureProg;
    logic setSector;
    logic loadWin;
    logic clearMask;
    logic fillMask;
  } seqStrobe_t;

endpackage

// File: rtl/cmdSeqCtrl.sv
module cmdSeqCtrl
  import flashCmdPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [CMD_ADDR_W-1:0] cmdAddr,
  input  logic [7:0]            wrData,
  input  logic                  progDone,
  input  logic                  eraseDone,
  input  logic                  winExpired,
  output seqStrobe_t            strobe,
  output logic [1:0]            mode
);

  seqState_e state, nextState;

  logic isKey1, isKey2, isReset, atKey1;

  assign atKey1  = (cmdAddr == ADDR_KEY1);
  assign isKey1  = atKey1 && (wrData == BYTE_KEY1);
  assign isKey2  = (cmdAddr == ADDR_KEY2) && (wrData == BYTE_KEY2);
  assign isReset = (wrData == BYTE_RESET);

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (wrValid) begin
          if (isReset) strobe.rstGo = 1'b1;
          else if (isKey1) nextState = ST_UNL1;
        end
      end
      ST_UNL1: begin
        if (wrValid) begin
          if (isKey2) nextState = ST_UNL2;
          else begin
            nextState    = ST_IDLE;
            strobe.rstGo = isReset;
          end
        end
      end
      ST_UNL2: begin
        if (wrValid) begin
          if (atKey1 && wrData == BYTE_PROG) nextState = ST_PROG_SETUP;
          else if (atKey1 && wrData == BYTE_IDENT) begin
            nextState     = ST_AUTOSEL;
            strobe.autoGo = 1'b1;
          end else if (atKey1 && wrData == BYTE_ERASE) nextState = ST_ERS_SETUP;
          else begin
            nextState    = ST_IDLE;
            strobe.rstGo = isReset;
          end
        end
      end
      ST_PROG_SETUP: begin
        if (wrValid) begin
          nextState          = ST_PROG_BUSY;
          strobe.progGo      = 1'b1;
          strobe.captureProg = 1'b1;
        end
      end
      ST_ERS_SETUP: begin
        if (wrValid) begin
          if (isKey1) nextState = ST_ERS_UNL1;
          else begin
            nextState    = ST_IDLE;
            strobe.rstGo = isReset;
          end
        end
      end
      ST_ERS_UNL1: begin
        if (wrValid) begin
          if (isKey2) nextState = ST_ERS_UNL2;
          else begin
            nextState    = ST_IDLE;
            strobe.rstGo = isReset;
          end
        end
      end
      ST_ERS_UNL2: begin
        if (wrValid) begin
          if (atKey1 && wrData == BYTE_CHIP) begin
            nextState       = ST_ERS_BUSY;
            strobe.chipGo   = 1'b1;
            strobe.fillMask = 1'b1;
          end else if (wrData == BYTE_SECTOR) begin
            nextState        = ST_SECT_WIN;
            strobe.setSector = 1'b1;
            strobe.loadWin   = 1'b1;
          end else begin
            nextState    = ST_IDLE;
            strobe.rstGo = isReset;
          end
        end
      end
      ST_SECT_WIN: begin
        if (wrValid) begin
          if (wrData == BYTE_SECTOR) begin
            strobe.setSector = 1'b1;
            strobe.loadWin   = 1'b1;
          end else if (wrData == BYTE_HALT) begin
            nextState     = ST_SUSPENDED;
            strobe.sectGo = 1'b1;
            strobe.suspGo = 1'b1;
          end else begin
            nextState        = ST_IDLE;
            strobe.clearMask = 1'b1;
            strobe.rstGo     = isReset;
          end
        end else if (winExpired) begin
          nextState     = ST_ERS_BUSY;
          strobe.sectGo = 1'b1;
        end
      end
      ST_PROG_BUSY: begin
        if (progDone) nextState = ST_IDLE;
      end
      ST_ERS_BUSY: begin
        if (eraseDone) begin
          nextState        = ST_IDLE;
          strobe.clearMask = 1'b1;
        end else if (wrValid && wrData == BYTE_HALT) begin
          nextState     = ST_SUSPENDED;
          strobe.suspGo = 1'b1;
        end
      end
      ST_SUSPENDED: begin
        if (wrValid && wrData == BYTE_SECTOR) begin
          nextState    = ST_ERS_BUSY;
          strobe.resGo = 1'b1;
        end
      end
      ST_AUTOSEL: begin
        if (wrValid && isReset) begin
          nextState    = ST_IDLE;
          strobe.rstGo = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    case (state)
      ST_AUTOSEL:                            mode = MODE_AUTOSEL;
      ST_PROG_BUSY, ST_ERS_BUSY, ST_SECT_WIN: mode = MODE_BUSY;
      ST_SUSPENDED:                          mode = MODE_SUSP;
      default:                               mode = MODE_READ;
    endcase
  end

  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG_BUSY && !progDone) |=> (state == ST_PROG_BUSY)); // R8

  AST_ERASE_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERS_BUSY && !eraseDone && !(wrValid && wrData == BYTE_HALT))
      |=> (state == ST_ERS_BUSY)); // R9

  AST_AUTOSEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AUTOSEL && !(wrValid && isReset)) |=> (state == ST_AUTOSEL)); // R3

endmodule

// File: rtl/cmdSeqData.sv
module cmdSeqData
  import flashCmdPkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned SEC_BITS      = 3,
  parameter int unsigned WINDOW_CYCLES = 6250,
  localparam int unsigned NUM_SECTORS  = 1 << SEC_BITS,
  localparam int unsigned CNT_W        = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  output logic                   winExpired,
  output logic                   progStart,
  output logic [ADDR_W-1:0]      progAddr,
  output logic [7:0]             progData,
  output logic                   chipEraseStart,
  output logic                   sectorEraseStart,
  output logic [NUM_SECTORS-1:0] sectorMask,
  output logic                   autoselEnter,
  output logic                   resetPulse,
  output logic                   suspendPulse,
  output logic                   resumePulse
);

  localparam logic [CNT_W-1:0] WIN_RELOAD = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0]       winCnt;
  logic [NUM_SECTORS-1:0] selHit;
  logic [SEC_BITS-1:0]    secIdx;

  assign secIdx = wrAddr[ADDR_W-1 -: SEC_BITS];

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_secDecode
    assign selHit[s] = (secIdx == SEC_BITS'(s));
  end

  always_ff @(posedge clk) begin
    if (!rstN)               winCnt <= '0;
    else if (strobe.loadWin) winCnt <= WIN_RELOAD;
    else if (winCnt != '0)   winCnt <= winCnt - 1'b1;
  end

  assign winExpired = (winCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                 sectorMask <= '0;
    else if (strobe.clearMask) sectorMask <= '0;
    else if (strobe.fillMask)  sectorMask <= '1;
    else if (strobe.setSector) sectorMask <= sectorMask | selHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strobe.captureProg) begin
      progAddr <= wrAddr;
      progData <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progStart        <= 1'b0;
      chipEraseStart   <= 1'b0;
      sectorEraseStart <= 1'b0;
      autoselEnter     <= 1'b0;
      resetPulse       <= 1'b0;
      suspendPulse     <= 1'b0;
      resumePulse      <= 1'b0;
    end else begin
      progStart        <= strobe.progGo;
      chipEraseStart   <= strobe.chipGo;
      sectorEraseStart <= strobe.sectGo;
      autoselEnter     <= strobe.autoGo;
      resetPulse       <= strobe.rstGo;
      suspendPulse     <= strobe.suspGo;
      resumePulse      <= strobe.resGo;
    end
  end

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearMask |=> (sectorMask == '0)); // R9

  AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setSector |=> ((sectorMask & $past(sectorMask)) == $past(sectorMask))); // R5

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sectorEraseStart |=> !sectorEraseStart); // R5

endmodule

// File: rtl/flashCmdDecoder.sv
module flashCmdDecoder
  import flashCmdPkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned SEC_BITS      = 3,
  parameter int unsigned WINDOW_CYCLES = 6250,
  localparam int unsigned NUM_SECTORS  = 1 << SEC_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  input  logic                   progDone,
  input  logic                   eraseDone,
  output logic                   progStart,
  output logic [ADDR_W-1:0]      progAddr,
  output logic [7:0]             progData,
  output logic                   chipEraseStart,
  output logic                   sectorEraseStart,
  output logic [NUM_SECTORS-1:0] sectorMask,
  output logic                   autoselEnter,
  output logic                   resetPulse,
  output logic                   suspendPulse,
  output logic                   resumePulse,
  output logic [1:0]             mode
);

  seqStrobe_t strobe;
  logic       winExpired;

  cmdSeqCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .cmdAddr   (wrAddr[CMD_ADDR_W-1:0]),
    .wrData    (wrData),
    .progDone  (progDone),
    .eraseDone (eraseDone),
    .winExpired(winExpired),
    .strobe    (strobe),
    .mode      (mode)
  );

  cmdSeqData #(
    .ADDR_W       (ADDR_W),
    .SEC_BITS     (SEC_BITS),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) i_data (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .wrAddr          (wrAddr),
    .wrData          (wrData),
    .winExpired      (winExpired),
    .progStart       (progStart),
    .progAddr        (progAddr),
    .progData        (progData),
    .chipEraseStart  (chipEraseStart),
    .sectorEraseStart(sectorEraseStart),
    .sectorMask      (sectorMask),
    .autoselEnter    (autoselEnter),
    .resetPulse      (resetPulse),
    .suspendPulse    (suspendPulse),
    .resumePulse     (resumePulse)
  );

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, chipEraseStart, sectorEraseStart, autoselEnter,
              resetPulse, resumePulse})); // R2

  AST_PROG_MODE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (mode == MODE_BUSY)); // R2

  AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> ($past(mode) == MODE_SUSP && mode == MODE_BUSY)); // R10

  AST_SUSPEND_MODE: assert property (@(posedge clk) disable iff (!rstN)
    suspendPulse |-> (mode == MODE_SUSP)); // R9

endmodule

// File: tb/test_flashCmdDecoder.sv
module test_flashCmdDecoder;

  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [18:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        progDone = 1'b0;
  logic        eraseDone = 1'b0;
  logic        progStart, chipEraseStart, sectorEraseStart, autoselEnter;
  logic        resetPulse, suspendPulse, resumePulse;
  logic [18:0] progAddr;
  logic [7:0]  progData;
  logic [7:0]  sectorMask;
  logic [1:0]  mode;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  flashCmdDecoder #(.ADDR_W(19), .SEC_BITS(3), .WINDOW_CYCLES(W)) i_flashCmdDecoder (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .progDone(progDone), .eraseDone(eraseDone), .progStart(progStart),
    .progAddr(progAddr), .progData(progData), .chipEraseStart(chipEraseStart),
    .sectorEraseStart(sectorEraseStart), .sectorMask(sectorMask),
    .autoselEnter(autoselEnter), .resetPulse(resetPulse),
    .suspendPulse(suspendPulse), .resumePulse(resumePulse), .mode(mode)
  );

  // pulse vector order: prog, chip, sector, autosel, reset, suspend, resume
  function automatic logic [6:0] pulses();
    return {progStart, chipEraseStart, sectorEraseStart, autoselEnter,
            resetPulse, suspendPulse, resumePulse};
  endfunction

  function automatic logic [7:0] secBit(input logic [18:0] a);
    return 8'(1) << a[18:16];
  endfunction

  function automatic logic [18:0] at(input logic [10:0] lo);
    return {8'($urandom), lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic finishProg();
    @(negedge clk); progDone = 1'b1;
    @(negedge clk); progDone = 1'b0;
  endtask

  task automatic finishErase();
    @(negedge clk); eraseDone = 1'b1;
    @(negedge clk); eraseDone = 1'b0;
  endtask

  task automatic eraseHead();
    wr(at(11'h555), 8'hAA); wr(at(11'h2AA), 8'h55); wr(at(11'h555), 8'h80);
    wr(at(11'h555), 8'hAA); wr(at(11'h2AA), 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [18:0] pa, sa, sb;
    logic [7:0]  pd;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mode", mode, 2'b00);
    chk("R1 pulses", pulses(), 7'b0);
    chk("R1 mask", sectorMask, 8'h00);

    // R2 directed program, R8 busy filter
    pa = 19'h5_1234; pd = 8'h3C;
    wr(at(11'h555), 8'hAA); wr(at(11'h2AA), 8'h55); wr(at(11'h555), 8'hA0);
    chk("R2 no early pulse", pulses(), 7'b0);
    wr(pa, pd);
    chk("R2 progStart", pulses(), 7'b1000000);
    chk("R2 progAddr", progAddr, pa);
    chk("R2 progData", progData, pd);
    chk("R2 mode busy", mode, 2'b10);
    @(negedge clk);
    chk("R2 one cycle", progStart, 1'b0);
    wr(at(11'h555), 8'hAA);
    chk("R8 unlock ignored", pulses(), 7'b0);
    wr(at(11'h123), 8'hF0);
    chk("R8 reset ignored", pulses(), 7'b0);
    chk("R8 still busy", mode, 2'b10);
    finishProg();
    chk("R8 done to read", mode, 2'b00);

    // R2/R7 random programs and aborted sequences
    for (int i = 0; i < 40; i++) begin
      int badStep;
      badStep = ($urandom % 2 == 0) ? -1 : int'($urandom % 3);
      pa = 19'($urandom); pd = 8'($urandom);
      for (int s = 0; s < 3; s++) begin
        logic [10:0] lo; logic [7:0] dd;
        lo = (s == 1) ? 11'h2AA : 11'h555;
        dd = (s == 0) ? 8'hAA : (s == 1) ? 8'h55 : 8'hA0;
        if (s == badStep) begin
          if ($urandom % 2 == 0) dd = dd ^ 8'h01; else lo = lo ^ 11'h004;
          wr(at(lo), dd);
          break;
        end
        wr(at(lo), dd);
      end
      if (badStep >= 0) begin
        chk("R7 abort mode", mode, 2'b00);
        chk("R7 abort pulses", pulses(), 7'b0);
      end else begin
        wr(pa, pd);
        chk("R2 rand pulse", pulses(), 7'b1000000);
        chk("R2 rand addr", progAddr, pa);
        chk("R2 rand data", progData, pd);
        finishProg();
      end
    end

    // R3 autoselect
    wr(at(11'h555), 8'hAA); wr(at(11'h2AA), 8'h55); wr(at(11'h555), 8'h90);
    chk("R3 autosel pulse", pulses(), 7'b0001000);
    chk("R3 mode", mode, 2'b01);
    wr(at(11'h555), 8'hAA);
    chk("R3 ignored pulse", pulses(), 7'b0);
    chk("R3 ignored mode", mode, 2'b01);
    wr(at(11'h7FF), 8'hF0);
    chk("R3 exit pulse", pulses(), 7'b0000100);
    chk("R3 exit mode", mode, 2'b00);

    // R7 reset between cycles
    wr(at(11'h555), 8'hAA);
    wr(at(11'h0AB), 8'hF0);
    chk("R7 reset pulse", pulses(), 7'b0000100);
    wr(at(11'h2AA), 8'h55); wr(at(11'h555), 8'hA0); wr(19'h1_0000, 8'h11);
    chk("R7 no program", pulses(), 7'b0);
    chk("R7 mode read", mode, 2'b00);

    // R4 chip erase, R9 suspend/filter, R10 resume
    eraseHead(); wr(at(11'h555), 8'h10);
    chk("R4 chip pulse", pulses(), 7'b0100000);
    chk("R4 mask full", sectorMask, 8'hFF);
    chk("R4 mode", mode, 2'b10);
    wr(at(11'h001), 8'hF0);
    chk("R9 reset ignored", pulses(), 7'b0);
    chk("R9 busy kept", mode, 2'b10);
    wr(at(11'h001), 8'hB0);
    chk("R9 suspend pulse", pulses(), 7'b0000010);
    chk("R9 mode susp", mode, 2'b11);
    wr(at(11'h555), 8'hAA);
    chk("R10 ignored in susp", mode, 2'b11);
    wr(at(11'h001), 8'h30);
    chk("R10 resume pulse", pulses(), 7'b0000001);
    chk("R10 mode busy", mode, 2'b10);
    finishErase();
    chk("R9 done mode", mode, 2'b00);
    chk("R9 mask cleared", sectorMask, 8'h00);
    wr(at(11'h001), 8'h30);
    chk("R10 no resume in read", pulses(), 7'b0);

    // R7 wrong sixth and fourth cycles
    eraseHead(); wr(at(11'h555), 8'h20);
    chk("R7 bad sixth mode", mode, 2'b00);
    chk("R7 bad sixth pulses", pulses(), 7'b0);
    wr(at(11'h555), 8'hAA); wr(at(11'h2AA), 8'h55); wr(at(11'h555), 8'h80);
    wr(at(11'h555), 8'hAB);
    chk("R7 bad fourth mode", mode, 2'b00);

    // R5 sector window timing
    sa = {3'd2, 16'h0040}; sb = {3'd5, 16'h1111};
    eraseHead(); wr(sa, 8'h30);
    chk("R5 mask first", sectorMask, secBit(sa));
    chk("R5 mode busy", mode, 2'b10);
    chk("R5 no pulse yet", pulses(), 7'b0);
    repeat (5) @(negedge clk);
    wr(sb, 8'h30);
    chk("R5 mask second", sectorMask, secBit(sa) | secBit(sb));
    for (int i = 1; i <= W + 1; i++) begin
      @(negedge clk);
      if (i == W) chk("R5 start at window end", sectorEraseStart, 1'b1);
      else        chk("R5 no start off window end", sectorEraseStart, 1'b0);
    end
    chk("R5 mode after start", mode, 2'b10);
    finishErase();

    // R12 write on the expiry edge
    eraseHead(); wr(sa, 8'h30);
    repeat (W - 2) @(negedge clk);
    wr({3'd7, 16'h0}, 8'h30);
    chk("R12 no start on reload", sectorEraseStart, 1'b0);
    chk("R12 mask grows", sectorMask, secBit(sa) | 8'h80);
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      if (i == W) chk("R12 start after fresh window", sectorEraseStart, 1'b1);
      else if (sectorEraseStart) chk("R12 early start", 1'b1, 1'b0);
    end
    finishErase();

    // R6 window abort
    eraseHead(); wr(sa, 8'h30);
    wr(at(11'h2AA), 8'h55);
    chk("R6 abort mode", mode, 2'b00);
    chk("R6 abort mask", sectorMask, 8'h00);
    chk("R6 abort pulses", pulses(), 7'b0);
    eraseHead(); wr(sb, 8'h30);
    wr(at(11'h3FF), 8'hF0);
    chk("R6 reset pulse", pulses(), 7'b0000100);
    chk("R6 reset mask", sectorMask, 8'h00);
    repeat (W + 2) @(negedge clk);
    chk("R6 no late start", sectorEraseStart, 1'b0);

    // R11 suspend inside window
    eraseHead(); wr(sb, 8'h30);
    wr(at(11'h000), 8'hB0);
    chk("R11 start and suspend", pulses(), 7'b0010010);
    chk("R11 mode susp", mode, 2'b11);
    chk("R11 mask kept", sectorMask, secBit(sb));
    wr(at(11'h000), 8'h30);
    chk("R10 resume after window", pulses(), 7'b0000001);
    finishErase();
    chk("R9 final read", mode, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule